// File: doc/BRIEF.md
# Packed 64-bit Integer Lane Unit

This block performs one integer operation on every lane of two 64-bit operands at once. The operands can be viewed as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane, and carries never pass from one lane into the next. The operations are wrap-around or clamping add and subtract, equality compare that returns a lane mask, bitwise logic, logical right shift, signed 16-bit multiply keeping either half of the product, a word-pair multiply-accumulate into 32-bit sums, narrowing with signed clamping, and lane interleave.

The datapath is purely combinational, and a single output register holds the result. An operation issued with its operands in one cycle therefore appears on `result` after the next rising clock edge. The opcode and the lane-size code are sampled in the same cycle as the operands.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes zero. Otherwise `result` takes the value computed from `op`, `lsize`, `opa` and `opb` sampled at that same edge. Lane size codes are 0 for 8-bit lanes, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit.
- R2: Opcodes 0 (add) and 3 (subtract) compute each lane modulo 2^lane width. No carry or borrow passes between lanes.
- R3: Opcodes 1 (add) and 4 (subtract) treat lanes as two's-complement numbers. A lane whose true result is above the largest signed value is set to that largest value. A lane whose true result is below the smallest signed value is set to that smallest value.
- R4: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned numbers. An add that exceeds the lane range gives all ones. A subtract that would go negative gives zero.
- R5: Opcode 6 sets a lane to all ones when the two operand lanes are equal, and to all zeros when they differ.
- R6: Opcodes 7, 8 and 9 give the bitwise AND, OR and XOR of the full 64 bits, whatever the value of `lsize`.
- R7: Opcode 10 shifts every lane of `opa` right logically by the unsigned 64-bit count in `opb`. When the count is equal to or larger than the lane width, every lane is zero.
- R8: Opcodes 11 and 12 multiply the four signed 16-bit lanes pairwise. Opcode 11 keeps bits 15:0 of each 32-bit product, and opcode 12 keeps bits 31:16. `lsize` has no effect.
- R9: Opcode 13 forms the four signed 16-bit products and adds them in pairs, wrapping to 32 bits. Products 0 and 1 go to bits 31:0, and products 2 and 3 go to bits 63:32.
- R10: Opcode 14 narrows signed lanes with clamping. With `lsize`=1, the 16-bit lanes of `opa` become bytes 3..0 and those of `opb` become bytes 7..4. With `lsize`=2, the 32-bit lanes of `opa` become 16-bit lanes 1..0 and those of `opb` become lanes 3..2.
- R11: Opcode 15 interleaves the low halves of the operands. Output lane 2i is lane i of `opa`, and output lane 2i+1 is lane i of `opb`, for `lsize` 0, 1 and 2.
- R12: Opcode 14 with `lsize` 0 or 3, and opcode 15 with `lsize` 3, give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| lsize | input | 2 | Lane size code |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand, or the shift count |
| result | output | 64 | Registered result |

## Verification
Operands are biased toward lane values of 0x7F..., 0x80..., all ones and zero. These values drive overflow in every lane at once. A carry chain that is not cut at the lane boundary would then corrupt the next lane, and a clamp that uses the wrong overflow test would wrap instead of saturating. Shift counts just below, at and well beyond each lane width expose a shifter that wraps the count or that only zeroes past 64. The multiply-accumulate is driven with -32768 in both lanes of a pair, which must wrap to 0x80000000. Narrowing is driven with values just inside and just outside the target range, where an off-by-one clamp shows up. Pack and interleave are also issued with the unused size codes, where a design must return zero rather than stale lanes.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DW = 64;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDSS  = 4'd1,
        OP_ADDUS  = 4'd2,
        OP_SUB    = 4'd3,
        OP_SUBSS  = 4'd4,
        OP_SUBUS  = 4'd5,
        OP_CMPEQ  = 4'd6,
        OP_AND    = 4'd7,
        OP_OR     = 4'd8,
        OP_XOR    = 4'd9,
        OP_SRL    = 4'd10,
        OP_MULLO  = 4'd11,
        OP_MULHI  = 4'd12,
        OP_MADD   = 4'd13,
        OP_NARROW = 4'd14,
        OP_WEAVE  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } lsize_e;

    typedef enum logic [1:0] {
        CLAMP_NONE     = 2'd0,
        CLAMP_SIGNED   = 2'd1,
        CLAMP_UNSIGNED = 2'd2
    } clamp_e;

    typedef struct packed {
        logic   sub;
        clamp_e clamp;
    } arith_ctl_t;

    function automatic arith_ctl_t arith_decode(input op_e op);
        arith_ctl_t c;
        c.sub = (op == OP_SUB) || (op == OP_SUBSS) || (op == OP_SUBUS);
        case (op)
            OP_ADDSS, OP_SUBSS: c.clamp = CLAMP_SIGNED;
            OP_ADDUS, OP_SUBUS: c.clamp = CLAMP_UNSIGNED;
            default:            c.clamp = CLAMP_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] clamp_16_to_8(input logic [15:0] x);
        if (!x[15] && (x[14:7] != 8'h00)) return 8'h7F;
        if (x[15] && (x[14:7] != 8'hFF))  return 8'h80;
        return x[7:0];
    endfunction

    function automatic logic [15:0] clamp_32_to_16(input logic [31:0] x);
        if (!x[31] && (x[30:15] != 16'h0000)) return 16'h7FFF;
        if (x[31] && (x[30:15] != 16'hFFFF))  return 16'h8000;
        return x[15:0];
    endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  arith_ctl_t    ctl,
    input  logic [DW-1:0] shamt,
    output logic [W-1:0]  arith,
    output logic [W-1:0]  eq_mask,
    output logic [W-1:0]  shr
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic [W-1:0] wrap;
    logic         s_ovf;
    logic         u_ovf;

    always_comb begin
        b_eff = ctl.sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ctl.sub};
        wrap  = full[W-1:0];
        s_ovf = (a[W-1] == b_eff[W-1]) && (wrap[W-1] != a[W-1]);
        u_ovf = ctl.sub ? !full[W] : full[W];
        case (ctl.clamp)
            CLAMP_SIGNED:   arith = s_ovf ? (a[W-1] ? {1'b1, {(W-1){1'b0}}}
                                                    : {1'b0, {(W-1){1'b1}}}) : wrap;
            CLAMP_UNSIGNED: arith = u_ovf ? (ctl.sub ? '0 : '1) : wrap;
            default:        arith = wrap;
        endcase
        eq_mask = (a == b) ? '1 : '0;
        shr     = (shamt >= DW'(W)) ? '0 : (a >> shamt[5:0]);
    end
endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] lo,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] madd
);
    localparam int NW = WIDTH / 16;
    localparam int NP = NW / 2;

    logic signed [31:0] prod [NW];

    for (genvar i = 0; i < NW; i++) begin : g_word
        assign prod[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
        assign lo[16*i +: 16] = prod[i][15:0];
        assign hi[16*i +: 16] = prod[i][31:16];
    end

    for (genvar j = 0; j < NP; j++) begin : g_pair
        assign madd[32*j +: 32] = prod[2*j] + prod[2*j+1];
    end
endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle
    import simd_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] narrow_w2b,
    output logic [WIDTH-1:0] narrow_d2w,
    output logic [WIDTH-1:0] weave_b,
    output logic [WIDTH-1:0] weave_w,
    output logic [WIDTH-1:0] weave_d
);
    localparam int NW = WIDTH / 16;
    localparam int ND = WIDTH / 32;
    localparam int NQ = WIDTH / 64;

    for (genvar i = 0; i < NW; i++) begin : g_w
        assign narrow_w2b[8*i +: 8]      = clamp_16_to_8(a[16*i +: 16]);
        assign narrow_w2b[8*(NW+i) +: 8] = clamp_16_to_8(b[16*i +: 16]);
        assign weave_b[16*i +: 8]        = a[8*i +: 8];
        assign weave_b[16*i+8 +: 8]      = b[8*i +: 8];
    end

    for (genvar i = 0; i < ND; i++) begin : g_d
        assign narrow_d2w[16*i +: 16]      = clamp_32_to_16(a[32*i +: 32]);
        assign narrow_d2w[16*(ND+i) +: 16] = clamp_32_to_16(b[32*i +: 32]);
        assign weave_w[32*i +: 16]         = a[16*i +: 16];
        assign weave_w[32*i+16 +: 16]      = b[16*i +: 16];
    end

    for (genvar i = 0; i < NQ; i++) begin : g_q
        assign weave_d[64*i +: 32]    = a[32*i +: 32];
        assign weave_d[64*i+32 +: 32] = b[32*i +: 32];
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op,
    input  logic [1:0]    lsize,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] result
);
    localparam int NSZ = 4;

    op_e        op_c;
    lsize_e     sz_c;
    arith_ctl_t ctl;

    assign op_c = op_e'(op);
    assign sz_c = lsize_e'(lsize);
    assign ctl  = arith_decode(op_c);

    logic [DW-1:0] arith_v [NSZ];
    logic [DW-1:0] eq_v    [NSZ];
    logic [DW-1:0] shr_v   [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = DW / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            simd_lane #(.W(LW)) lane_i (
                .a       (opa[LW*l +: LW]),
                .b       (opb[LW*l +: LW]),
                .ctl     (ctl),
                .shamt   (opb),
                .arith   (arith_v[s][LW*l +: LW]),
                .eq_mask (eq_v[s][LW*l +: LW]),
                .shr     (shr_v[s][LW*l +: LW])
            );
        end
    end

    logic [DW-1:0] mul_lo, mul_hi, mul_madd;
    simd_mul #(.WIDTH(DW)) mul_i (
        .a    (opa),
        .b    (opb),
        .lo   (mul_lo),
        .hi   (mul_hi),
        .madd (mul_madd)
    );

    logic [DW-1:0] nar_wb, nar_dw, wv_b, wv_w, wv_d;
    simd_shuffle #(.WIDTH(DW)) shuf_i (
        .a          (opa),
        .b          (opb),
        .narrow_w2b (nar_wb),
        .narrow_d2w (nar_dw),
        .weave_b    (wv_b),
        .weave_w    (wv_w),
        .weave_d    (wv_d)
    );

    logic [DW-1:0] next_res;

    always_comb begin
        case (op_c)
            OP_ADD, OP_ADDSS, OP_ADDUS,
            OP_SUB, OP_SUBSS, OP_SUBUS: next_res = arith_v[sz_c];
            OP_CMPEQ:  next_res = eq_v[sz_c];
            OP_AND:    next_res = opa & opb;
            OP_OR:     next_res = opa | opb;
            OP_XOR:    next_res = opa ^ opb;
            OP_SRL:    next_res = shr_v[sz_c];
            OP_MULLO:  next_res = mul_lo;
            OP_MULHI:  next_res = mul_hi;
            OP_MADD:   next_res = mul_madd;
            OP_NARROW: begin
                case (sz_c)
                    SZ_16:   next_res = nar_wb;
                    SZ_32:   next_res = nar_dw;
                    default: next_res = '0;
                endcase
            end
            OP_WEAVE: begin
                case (sz_c)
                    SZ_8:    next_res = wv_b;
                    SZ_16:   next_res = wv_w;
                    SZ_32:   next_res = wv_d;
                    default: next_res = '0;
                endcase
            end
            default:   next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= next_res;
    end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [3:0]    op,
    input logic [1:0]    lsize,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] opb,
    input logic [DW-1:0] result
);
    // R1: reset clears the output register
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0));

    // R5: identical operands give an all-ones mask at any lane size
    a_r5_equal_all_ones: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd6 && opa == opb) |=> (result == '1));

    // R6: XOR of an operand with itself clears every bit
    a_r6_xor_self_zero: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd9 && opa == opb) |=> (result == '0));

    // R7: a count of 64 or more empties every lane size
    a_r7_big_shift_zero: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd10 && opb >= 64'd64) |=> (result == '0));

    // R4: all-ones plus any nonzero value stays all-ones
    a_r4_unsigned_ceiling: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd2 && opa == '1 && opb != '0) |=> (result == '1));

    // R12: narrowing at an unsupported size produces zero
    a_r12_narrow_bad_size: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd14 && (lsize == 2'd0 || lsize == 2'd3)) |=> (result == '0));
endmodule

bind simd_alu simd_alu_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .lsize  (lsize),
    .opa    (opa),
    .opb    (opb),
    .result (result)
);

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic [1:0]  lsize = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    simd_alu dut_i (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .lsize  (lsize),
        .opa    (opa),
        .opb    (opb),
        .result (result)
    );

    function automatic string req_of(input logic [3:0] o, input logic [1:0] s);
        case (o)
            4'd0, 4'd3: return "R2";
            4'd1, 4'd4: return "R3";
            4'd2, 4'd5: return "R4";
            4'd6:       return "R5";
            4'd7, 4'd8, 4'd9: return "R6";
            4'd10:      return "R7";
            4'd11, 4'd12: return "R8";
            4'd13:      return "R9";
            4'd14:      return (s == 2'd1 || s == 2'd2) ? "R10" : "R12";
            default:    return (s == 2'd3) ? "R12" : "R11";
        endcase
    endfunction

    function automatic logic [63:0] lane_math(input logic [3:0] o, input int w,
                                              input logic [63:0] x, input logic [63:0] y);
        logic signed [66:0] sx, sy, s, mx, mn;
        logic [66:0] ux, uy, m;
        ux = {3'b0, x};
        uy = {3'b0, y};
        m  = (67'd1 << w) - 67'd1;
        sx = $signed(ux);
        sy = $signed(uy);
        if (x[w-1]) sx = sx - (67'sd1 <<< w);
        if (y[w-1]) sy = sy - (67'sd1 <<< w);
        mx = (67'sd1 <<< (w-1)) - 67'sd1;
        mn = -(67'sd1 <<< (w-1));
        case (o)
            4'd0: return x + y;
            4'd3: return x - y;
            4'd1, 4'd4: begin
                s = (o == 4'd4) ? sx - sy : sx + sy;
                if (s > mx) s = mx;
                if (s < mn) s = mn;
                return s[63:0];
            end
            4'd2:    return (ux + uy > m) ? m[63:0] : x + y;
            default: return (ux < uy) ? 64'd0 : x - y;
        endcase
    endfunction

    function automatic logic [63:0] sat_narrow(input logic [63:0] x, input int w);
        logic signed [66:0] sx, mx, mn;
        sx = $signed({3'b0, x});
        if (x[w-1]) sx = sx - (67'sd1 <<< w);
        mx = (67'sd1 <<< (w/2 - 1)) - 67'sd1;
        mn = -(67'sd1 <<< (w/2 - 1));
        if (sx > mx) sx = mx;
        if (sx < mn) sx = mn;
        return sx[63:0] & ((64'd1 << (w/2)) - 64'd1);
    endfunction

    function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        int w;
        int n;
        logic [63:0] m, r, x, y;
        logic signed [31:0] p [4];
        w = 8 << sz;
        n = 64 / w;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int k = 0; k < 4; k++)
            p[k] = 32'($signed(a[16*k +: 16])) * 32'($signed(b[16*k +: 16]));
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd10: begin
                for (int i = 0; i < n; i++) begin
                    x = (a >> (i*w)) & m;
                    y = (b >> (i*w)) & m;
                    if (o == 4'd6)       x = (x == y) ? m : 64'd0;
                    else if (o == 4'd10) x = (b >= 64'(w)) ? 64'd0 : (x >> b);
                    else                 x = lane_math(o, w, x, y);
                    r = r | ((x & m) << (i*w));
                end
            end
            4'd7: r = a & b;
            4'd8: r = a | b;
            4'd9: r = a ^ b;
            4'd11, 4'd12: for (int k = 0; k < 4; k++)
                r[16*k +: 16] = (o == 4'd11) ? p[k][15:0] : p[k][31:16];
            4'd13: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            4'd14: if (sz == 2'd1 || sz == 2'd2) begin
                for (int i = 0; i < n; i++) begin
                    r = r | (sat_narrow((a >> (i*w)) & m, w) << (i*w/2));
                    r = r | (sat_narrow((b >> (i*w)) & m, w) << ((n+i)*w/2));
                end
            end
            default: if (sz != 2'd3) begin
                for (int i = 0; i < n/2; i++) begin
                    r = r | (((a >> (i*w)) & m) << (2*i*w));
                    r = r | (((b >> (i*w)) & m) << ((2*i+1)*w));
                end
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d lsize=%0d a=%h b=%h got %h expected %h",
                     req, op, lsize, opa, opb, result, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [1:0] s,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op = o; lsize = s; opa = a; opb = b;
        @(negedge clk);
        check(req_of(o, s), model(o, s, a, b));
    endtask

    function automatic logic [63:0] pick_operand();
        case ($urandom_range(0, 9))
            0: return 64'h7F7F_7F7F_7F7F_7F7F;
            1: return 64'h8080_8080_8080_8080;
            2: return '1;
            3: return '0;
            4: return 64'h7FFF_7FFF_7FFF_7FFF;
            5: return 64'h8000_8000_8000_8000;
            6: return 64'h7FFF_FFFF_7FFF_FFFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'd20240611));

        // R1: reset state, even with live inputs
        op = 4'd8; opa = '1; opb = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 64'd0);
        rst = 1'b0;

        // R1: one-cycle latency, value taken from the sampled inputs
        apply(4'd7, 2'd0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF);

        // R2: carry must not cross lanes
        apply(4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
        // R3: signed clamp at both ends
        apply(4'd1, 2'd1, 64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_7FFF_0001);
        apply(4'd4, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF);
        // R4: unsigned ceiling and floor
        apply(4'd2, 2'd0, 64'hFF80_0102_0304_0506, 64'h0180_FF00_0000_0000);
        apply(4'd5, 2'd3, 64'd5, 64'd6);
        // R7: counts just below, at and beyond lane width
        apply(4'd10, 2'd1, 64'h8000_8000_8000_8000, 64'd15);
        apply(4'd10, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16);
        apply(4'd10, 2'd3, 64'h8000_0000_0000_0000, 64'd63);
        apply(4'd10, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0003);
        // R9: extreme pair wraps to 0x80000000
        apply(4'd13, 2'd0, 64'h8000_8000_0003_FFFE, 64'h8000_8000_0004_0002);
        // R10: values at the edges of the narrow range
        apply(4'd14, 2'd1, 64'h007F_0080_FF80_FF7F, 64'h8000_7FFF_0000_FFFF);
        apply(4'd14, 2'd2, 64'h0000_7FFF_0000_8000, 64'hFFFF_8000_FFFF_7FFF);
        // R11 and R12: interleave and its dead size code
        apply(4'd15, 2'd0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
        apply(4'd15, 2'd3, 64'h1234, 64'h5678);
        apply(4'd14, 2'd0, 64'h1234, 64'h5678);
        // R6 and R8: size code has no effect
        apply(4'd9, 2'd3, 64'hAAAA_5555_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(4'd12, 2'd2, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0001_0003);

        // Random sweep over every opcode and lane size
        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 4; s++) begin
                for (int t = 0; t < 40; t++) begin
                    a = pick_operand();
                    b = pick_operand();
                    if (o == 6 && t[0]) b = a;
                    if (o == 10) b = (t % 5 == 4) ? {$urandom, $urandom} : 64'($urandom_range(0, 70));
                    apply(4'(o), 2'(s), a, b);
                end
            end
        end

        // R1: reset mid-stream clears the result again
        @(negedge clk);
        rst = 1'b1; op = 4'd8; opa = '1; opb = '1;
        @(negedge clk);
        check("R1", 64'd0);

        summary();
        $finish;
    end
endmodule